// File: doc/BRIEF.md
# Carry-Chain Magnitude Comparator

This block compares two unsigned N-bit operands and reports strict less-than or strict greater-than, as chosen per transfer by a mode bit. An equality flag is reported alongside. The comparison is built as an explicit ripple chain, written in plain RTL, that behaves like a programmable-logic carry chain. The operands are cut into chunks, CHUNK bits wide (2 by default). Each chunk either drives a fixed value onto the chain, when its two operand pieces differ, or passes along the value arriving from below, when they match. The bottom of the chain is tied low and the top of the chain is the answer. The most significant unequal chunk therefore decides the result. Greater-than reuses the same chain with the operands swapped.

Operands enter through a valid/ready stream. A transfer happens on a rising clock edge where `in_valid` and `in_ready` are both high. With the default registered output stage, the result is held on a valid/ready output until it is taken. A new transfer is accepted only when the output register is empty or is being drained in the same cycle, so back-pressure on `out_ready` reaches `in_ready` in the same cycle. The producer must hold `in_valid` and the operands steady until they are accepted.

Top module: `carry_cmp`

## Requirements
- R1: With `in_mode` = 0 (less-than), `out_hit` is 1 exactly when `in_a` < `in_b` as unsigned numbers.
- R2: With `in_mode` = 1 (greater-than), `out_hit` is 1 exactly when `in_a` > `in_b` as unsigned numbers.
- R3: Equal operands give `out_hit` = 0 in both modes.
- R4: `out_equal` is 1 exactly when `in_a` = `in_b`, whatever the mode.
- R5: The most significant chunk whose operand pieces differ sets the result, whatever the less significant bits hold.
- R6: For an odd N, the top chunk is a single bit and R1 to R4 still hold.
- R7: A transfer accepted on a rising edge shows its result, with `out_valid` high, right after that edge. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_hit` and `out_equal` stay unchanged. After an edge where `out_ready` is high and no transfer is accepted, `out_valid` is low.
- R8: `in_ready` equals `!out_valid || out_ready` at all times.
- R9: While `rst_n` is low and after it is released, `out_valid` is 0 and `in_ready` is 1 until the first transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand transfer offered |
| in_ready | output | 1 | Operand transfer can be taken |
| in_a | input | N | First operand, unsigned |
| in_b | input | N | Second operand, unsigned |
| in_mode | input | 1 | 0 = less-than, 1 = greater-than |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_hit | output | 1 | Comparison outcome |
| out_equal | output | 1 | Operands were equal |

## Verification
Every result is due one clock after the edge that accepts its operands: it is written into the output register on that edge and is visible from then on. The bench changes inputs and samples outputs on falling edges, so each check reads the result of the transfer accepted on the rising edge just before. In the back-pressure case, the held result is read over several falling edges while `out_ready` is low. The next result is read one falling edge after `out_ready` returns high.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef enum logic {
    CMP_LT = 1'b0,
    CMP_GT = 1'b1
  } cmp_mode_e;

  typedef struct packed {
    logic hit;
    logic equal;
  } cmp_res_t;
endpackage

// File: rtl/cmp_slice.sv
// One chunk of the chain: reports whether it passes the carry (match)
// and which value it forces when its operand pieces differ.
module cmp_slice #(
  parameter int W = 2
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic         frc,
  output logic         prp
);
  always_comb begin : bit_ripple
    logic r;
    r = 1'b0;
    for (int k = 0; k < W; k++) begin
      r = (x[k] == y[k]) ? r : y[k];
    end
    frc = r;
  end

  assign prp = (x == y);
endmodule

// File: rtl/cmp_chain.sv
// Ripple chain across chunks, least significant chunk at the bottom.
module cmp_chain #(
  parameter int N     = 8,
  parameter int CHUNK = 2
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic         tie,
  output logic         top,
  output logic         all_eq
);
  localparam int NCH  = (N + CHUNK - 1) / CHUNK;
  localparam int TOPW = N - CHUNK * (NCH - 1);

  logic [NCH-1:0] frc;
  logic [NCH-1:0] prp;

  for (genvar i = 0; i < NCH; i++) begin : g_slice
    localparam int LO = i * CHUNK;
    localparam int W  = (i == NCH - 1) ? TOPW : CHUNK;
    cmp_slice #(.W(W)) u_slice (
      .x   (x[LO +: W]),
      .y   (y[LO +: W]),
      .frc (frc[i]),
      .prp (prp[i])
    );
  end

  always_comb begin : chunk_ripple
    logic r;
    r = tie;
    for (int i = 0; i < NCH; i++) begin
      r = prp[i] ? r : frc[i];
    end
    top = r;
  end

  assign all_eq = &prp;
endmodule

// File: rtl/cmp_out_stage.sv
module cmp_out_stage
  import cmp_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  cmp_res_t in_res,
  output logic     out_valid,
  input  logic     out_ready,
  output cmp_res_t out_res
);
  if (OUT_REG) begin : g_reg
    logic     vld_q;
    cmp_res_t res_q;

    assign in_ready = !vld_q || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        res_q <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) res_q <= in_res;
      end
    end

    assign out_valid = vld_q;
    assign out_res   = res_q;
  end else begin : g_pass
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_res   = in_res;
  end
endmodule

// File: rtl/carry_cmp.sv
module carry_cmp
  import cmp_pkg::*;
#(
  parameter int N       = 8,
  parameter int CHUNK   = 2,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_a,
  input  logic [N-1:0] in_b,
  input  logic         in_mode,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         out_hit,
  output logic         out_equal
);
  localparam logic CHAIN_TIE = 1'b0;

  cmp_mode_e    mode;
  logic [N-1:0] op_x;
  logic [N-1:0] op_y;
  logic         chain_top;
  logic         chain_eq;
  cmp_res_t     res_d;
  cmp_res_t     res_q;

  assign mode = cmp_mode_e'(in_mode);

  // Greater-than reuses the less-than chain with operands exchanged.
  always_comb begin
    if (mode == CMP_GT) begin
      op_x = in_b;
      op_y = in_a;
    end else begin
      op_x = in_a;
      op_y = in_b;
    end
  end

  cmp_chain #(.N(N), .CHUNK(CHUNK)) u_chain (
    .x      (op_x),
    .y      (op_y),
    .tie    (CHAIN_TIE),
    .top    (chain_top),
    .all_eq (chain_eq)
  );

  assign res_d.hit   = chain_top;
  assign res_d.equal = chain_eq;

  cmp_out_stage #(.OUT_REG(OUT_REG)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_res    (res_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_res   (res_q)
  );

  assign out_hit   = res_q.hit;
  assign out_equal = res_q.equal;
endmodule

// File: rtl/carry_cmp_chk.sv
module carry_cmp_chk #(
  parameter int N       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [N-1:0] in_a,
  input logic [N-1:0] in_b,
  input logic         in_mode,
  input logic         out_valid,
  input logic         out_ready,
  input logic         out_hit,
  input logic         out_equal
);
  a_r3_equal_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_equal) |-> !out_hit);

  if (OUT_REG) begin : g_reg_checks
    a_r1_less: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !in_mode) |=> (out_hit == ($past(in_a) < $past(in_b))));

    a_r2_greater: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_mode) |=> (out_hit == ($past(in_a) > $past(in_b))));

    a_r4_equal_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_equal == ($past(in_a) == $past(in_b))));

    a_r7_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_hit) && $stable(out_equal)));

    a_r8_ready_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);
  end
endmodule

bind carry_cmp carry_cmp_chk #(.N(N), .OUT_REG(OUT_REG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_a      (in_a),
  .in_b      (in_b),
  .in_mode   (in_mode),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_hit   (out_hit),
  .out_equal (out_equal)
);

// File: tb/carry_cmp_tb.sv
module carry_cmp_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // N = 8 instance
  logic       v8 = 0, m8 = 0, or8 = 1;
  logic [7:0] a8 = '0, b8 = '0;
  logic       r8, ov8, h8, e8;
  // N = 32 instance
  logic        v32 = 0, m32 = 0, or32 = 1;
  logic [31:0] a32 = '0, b32 = '0;
  logic        r32, ov32, h32, e32;
  // N = 7 instance
  logic       v7 = 0, m7 = 0, or7 = 1;
  logic [6:0] a7 = '0, b7 = '0;
  logic       r7, ov7, h7, e7;

  carry_cmp #(.N(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(v8), .in_ready(r8), .in_a(a8), .in_b(b8),
    .in_mode(m8), .out_valid(ov8), .out_ready(or8), .out_hit(h8), .out_equal(e8));
  carry_cmp #(.N(32)) u_dut32 (
    .clk(clk), .rst_n(rst_n), .in_valid(v32), .in_ready(r32), .in_a(a32), .in_b(b32),
    .in_mode(m32), .out_valid(ov32), .out_ready(or32), .out_hit(h32), .out_equal(e32));
  carry_cmp #(.N(7)) u_dut7 (
    .clk(clk), .rst_n(rst_n), .in_valid(v7), .in_ready(r7), .in_a(a7), .in_b(b7),
    .in_mode(m7), .out_valid(ov7), .out_ready(or7), .out_hit(h7), .out_equal(e7));

  function automatic logic [31:0] wmask(int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  function automatic logic exp_hit(logic [31:0] a, logic [31:0] b, logic m, int w);
    logic [31:0] aa = a & wmask(w);
    logic [31:0] bb = b & wmask(w);
    return m ? (aa > bb) : (aa < bb);
  endfunction

  function automatic logic exp_eq(logic [31:0] a, logic [31:0] b, int w);
    return (a & wmask(w)) == (b & wmask(w));
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // Called on a falling edge; offers one transfer, checks it one clock later.
  task automatic run_vec(int w, logic [31:0] a, logic [31:0] b, logic m, string tag);
    logic hv, hh, he;
    string t;
    case (w)
      8:  begin v8 = 1;  a8 = a[7:0];  b8 = b[7:0];  m8 = m;  end
      32: begin v32 = 1; a32 = a;      b32 = b;      m32 = m; end
      default: begin v7 = 1; a7 = a[6:0]; b7 = b[6:0]; m7 = m; end
    endcase
    @(negedge clk);
    case (w)
      8:  begin hv = ov8;  hh = h8;  he = e8;  end
      32: begin hv = ov32; hh = h32; he = e32; end
      default: begin hv = ov7; hh = h7; he = e7; end
    endcase
    if (tag != "") t = tag;
    else if (w == 7) t = "R6";
    else if (exp_eq(a, b, w)) t = "R3";
    else t = m ? "R2" : "R1";
    check("R7", "out_valid", hv, 1'b1);
    check(t, "out_hit", hh, exp_hit(a, b, m, w));
    check((w == 7) ? "R6" : "R4", "out_equal", he, exp_eq(a, b, w));
  endtask

  task automatic idle_all();
    v8 = 0; v32 = 0; v7 = 0;
  endtask

  task automatic run_all();
    logic [31:0] ra, rb;
    void'($urandom(32'h5EED_C0DE));
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "out_valid n8", ov8, 1'b0);
    check("R9", "in_ready n8", r8, 1'b1);
    check("R9", "out_valid n32", ov32, 1'b0);
    check("R9", "out_valid n7", ov7, 1'b0);
    rst_n = 1;
    @(negedge clk);
    check("R9", "out_valid after release", ov8, 1'b0);
    check("R9", "in_ready after release", r8, 1'b1);

    // R5: directed, top chunk overrides lower bits
    run_vec(8, 32'h3F, 32'h40, 1'b0, "R5");
    run_vec(8, 32'h80, 32'h7F, 1'b0, "R5");
    run_vec(8, 32'h80, 32'h7F, 1'b1, "R5");
    run_vec(8, 32'h01, 32'hFE, 1'b1, "R5");
    run_vec(32, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0, "R5");
    run_vec(32, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, "R5");
    run_vec(32, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0, "R1");
    run_vec(32, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b1, "R2");
    run_vec(32, 32'h0, 32'h0, 1'b0, "R3");
    run_vec(32, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R3");
    run_vec(7, 32'h40, 32'h3F, 1'b1, "R6");
    run_vec(7, 32'h3F, 32'h40, 1'b1, "R6");
    idle_all();
    @(negedge clk);

    // R1..R4: exhaustive N=8 pairs, mode alternating per vector
    for (int k = 0; k < 65536; k++) begin
      run_vec(8, 32'(k >> 8), 32'(k & 255), k[0] ^ k[8], "");
    end
    // R1, R2: random N=8 in both modes
    for (int k = 0; k < 4000; k++) begin
      run_vec(8, $urandom, $urandom, k[0], "");
    end
    idle_all();
    @(negedge clk);
    check("R7", "out_valid drops when idle", ov8, 1'b0);

    // R6: exhaustive N=7 pairs
    for (int k = 0; k < 16384; k++) begin
      run_vec(7, 32'(k >> 7), 32'(k & 127), k[0] ^ k[7], "");
    end
    idle_all();

    // N=32 random, with some equal pairs
    for (int k = 0; k < 20000; k++) begin
      ra = $urandom;
      rb = ($urandom % 8 == 0) ? ra : $urandom;
      if ($urandom % 4 == 0) rb = ra ^ (32'd1 << ($urandom % 32));
      run_vec(32, ra, rb, $urandom % 2 == 1, "");
    end
    idle_all();
    @(negedge clk);

    // R7, R8: back-pressure on the N=8 instance
    run_vec(8, 32'h10, 32'h20, 1'b0, "R7");      // hit 1, equal 0
    or8 = 0;
    v8 = 1; a8 = 8'h55; b8 = 8'h55; m8 = 1'b0;   // hit 0, equal 1
    #1;
    check("R8", "in_ready while stalled", r8, 1'b0);
    repeat (3) begin
      @(negedge clk);
      check("R7", "held out_valid", ov8, 1'b1);
      check("R7", "held out_hit", h8, 1'b1);
      check("R7", "held out_equal", e8, 1'b0);
      check("R8", "in_ready while stalled", r8, 1'b0);
    end
    or8 = 1;
    #1;
    check("R8", "in_ready when draining", r8, 1'b1);
    @(negedge clk);
    check("R7", "next out_valid", ov8, 1'b1);
    check("R7", "next out_hit", h8, 1'b0);
    check("R7", "next out_equal", e8, 1'b1);
    v8 = 0;
    @(negedge clk);
    check("R7", "out_valid after drain", ov8, 1'b0);
    check("R8", "in_ready when empty", r8, 1'b1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule